// File: doc/BRIEF.md
# Packed Day-Time Counter with Alarms

This block keeps the time of day and a running day number in a single 32-bit packed word. It advances the word by one second on each count step. Count steps come from a slow reference tick, nominally 32.768 kHz, presented as a one-cycle enable on the system clock. With the divider switched on, a prescaler turns the reference ticks into one step per second. With the divider switched off, every reference tick is a step.

Each step produces one-cycle event pulses:

- a second pulse on every step;
- minute, hour and day-rollover pulses when the lower fields wrap;
- two alarm pulses, from comparing the new count against a stored alarm word:
  - a time-of-day match that ignores the day number;
  - a full-word match that includes the day number.

A 16-bit down-counting stopwatch shares the same step. It pulses its own event once, when it reaches zero.

The time word, the alarm word and the stopwatch are loaded through strobe inputs. A load strobe takes priority over a step that falls in the same cycle.

Top module: `pkd_timekeeper`

## Requirements
- R1: After reset the time word and the stopwatch read 0 and no event pulse is active.
- R2: Each count step adds one to the seconds field (bits 5:0), which runs 0..59. In the cycle after the step, bit 2 (0x0004) of `event_pulse` is high for one cycle.
- R3: A step taken when the seconds field reads 59 sets the seconds field to 0 and increments the minutes field (bits 11:6). It also pulses bit 3 (0x0008).
- R4: A step that wraps the minutes field from 59 to 0 increments the hours field (bits 16:12). It also pulses bit 4 (0x0010).
- R5: A step that wraps the hours field from 23 to 0 increments the day field (bits 31:17). It also pulses bit 5 (0x0020). The day field wraps from 32767 to 0.
- R6: With `div_en` high, one count step occurs every PRESCALE_DIV reference ticks. With `div_en` low, every reference tick is a count step.
- R7: `time_load` replaces the time word and clears the prescaler phase, so the next step comes a full divider period later. A step that falls in the load cycle is dropped: it causes no event and no stopwatch decrement.
- R8: Bit 1 (0x0002) pulses after a step whose new time word equals the alarm word in bits 16:0. The day field is ignored for this match.
- R9: Bit 6 (0x0040) pulses after a step whose new time word equals the alarm word in all 32 bits. Bit 1 always pulses with it.
- R10: The stopwatch decrements by one on each step while it is nonzero, and then holds at 0. Bit 0 (0x0001) pulses on the step that takes it from 1 to 0.
- R11: `swatch_load` replaces the stopwatch value and wins over a step in the same cycle.
- R12: `alarm_load` replaces the alarm word. The comparison after later steps uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle reference tick (nominally 32.768 kHz) |
| div_en | input | 1 | Prescaler on (1) or bypassed (0) |
| time_load | input | 1 | Load strobe for the time word |
| time_load_val | input | 32 | Packed time value to load |
| alarm_load | input | 1 | Load strobe for the alarm word |
| alarm_load_val | input | 32 | Packed alarm value to load |
| swatch_load | input | 1 | Load strobe for the stopwatch |
| swatch_load_val | input | SW_W | Stopwatch value to load |
| time_word | output | 32 | Current packed time word |
| swatch_word | output | SW_W | Current stopwatch value |
| event_pulse | output | 7 | One-cycle event pulses, bit 0 stopwatch through bit 6 day alarm |

## Verification
Two kinds of collision are provoked by driving a reference tick and a load strobe in the same cycle:

- a time load together with a step;
- a stopwatch load together with a step.

Each collision is judged by checking that the loaded value appears unmodified and that no event pulse follows.

Coincident events are also checked. The bench drives the counter onto an alarm match that falls on the same step as a full-word match. It also drives full rollovers across the minute, hour and day fields. In each case the complete `event_pulse` vector is compared, so a missing or extra bit in the same cycle is reported.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned EVT_W    = 7;
   localparam int unsigned SEC_LAST = 59;
   localparam int unsigned MIN_LAST = 59;
   localparam int unsigned HR_LAST  = 23;

   localparam int unsigned EVT_SW   = 0;
   localparam int unsigned EVT_TALM = 1;
   localparam int unsigned EVT_SEC  = 2;
   localparam int unsigned EVT_MIN  = 3;
   localparam int unsigned EVT_HR   = 4;
   localparam int unsigned EVT_DAY  = 5;
   localparam int unsigned EVT_DALM = 6;

   localparam int unsigned TOD_BITS = 17;

   typedef struct packed {
      logic [14:0] day;
      logic [4:0]  hr;
      logic [5:0]  min;
      logic [5:0]  sec;
   } tod_t;

endpackage

// File: rtl/pkd_prescaler.sv
module pkd_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick_i,
   input  logic div_en_i,
   input  logic load_i,
   output logic step_o
);
   localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("pkd_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_bypass
      assign step_o = osc_tick_i & ~load_i;
   end else begin : g_div
      logic [PH_W-1:0] phase_q;
      logic            at_end;

      assign at_end = (phase_q == PH_W'(DIV - 1));
      assign step_o = osc_tick_i & ~load_i & (~div_en_i | at_end);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (load_i || !div_en_i) begin
            phase_q <= '0;
         end else if (osc_tick_i) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
         end
      end

      AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         load_i |=> (phase_q == '0)); // R7
      AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (phase_q <= PH_W'(DIV - 1))); // R6
   end

   AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> osc_tick_i); // R6
endmodule

// File: rtl/pkd_tod_counter.sv
module pkd_tod_counter
   import pkd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_val_i,
   output logic [WORD_W-1:0] cnt_o,
   output logic [WORD_W-1:0] next_o,
   output logic [3:0]        roll_evt_o
);
   tod_t cur_q, nxt;
   logic sec_wrap, min_wrap, hr_wrap;
   logic c_min, c_hr, c_day;
   logic evt_sec_q, evt_min_q, evt_hr_q, evt_day_q;

   always_comb begin
      sec_wrap = (cur_q.sec >= 6'(SEC_LAST));
      min_wrap = (cur_q.min >= 6'(MIN_LAST));
      hr_wrap  = (cur_q.hr  >= 5'(HR_LAST));
      c_min    = sec_wrap;
      c_hr     = c_min & min_wrap;
      c_day    = c_hr & hr_wrap;
      nxt      = cur_q;
      nxt.sec  = sec_wrap ? '0 : cur_q.sec + 1'b1;
      if (c_min) nxt.min = min_wrap ? '0 : cur_q.min + 1'b1;
      if (c_hr)  nxt.hr  = hr_wrap  ? '0 : cur_q.hr + 1'b1;
      if (c_day) nxt.day = cur_q.day + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         evt_sec_q <= 1'b0;
         evt_min_q <= 1'b0;
         evt_hr_q  <= 1'b0;
         evt_day_q <= 1'b0;
      end else begin
         if (load_i) begin
            cur_q <= tod_t'(load_val_i);
         end else if (step_i) begin
            cur_q <= nxt;
         end
         evt_sec_q <= step_i & ~load_i;
         evt_min_q <= step_i & ~load_i & c_min;
         evt_hr_q  <= step_i & ~load_i & c_hr;
         evt_day_q <= step_i & ~load_i & c_day;
      end
   end

   assign cnt_o      = cur_q;
   assign next_o     = nxt;
   assign roll_evt_o = {evt_day_q, evt_hr_q, evt_min_q, evt_sec_q};

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_o == $past(load_val_i))); // R7
   AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && cur_q.sec < 6'(SEC_LAST)) |=> (cur_q.sec == $past(cur_q.sec) + 6'd1)); // R2
   AST_MIN_AT_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      evt_min_q |-> (cur_q.sec == '0)); // R3
   AST_HR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      evt_hr_q |-> (evt_min_q && cur_q.min == '0)); // R4
   AST_DAY_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      evt_day_q |-> (evt_hr_q && cur_q.hr == '0)); // R5
endmodule

// File: rtl/pkd_alarm_cmp.sv
module pkd_alarm_cmp
   import pkd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              time_load_i,
   input  logic [WORD_W-1:0] next_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_val_i,
   output logic              tod_evt_o,
   output logic              day_evt_o
);
   logic [WORD_W-1:0] alarm_q;
   logic              tod_hit, day_hit;

   assign tod_hit = (next_i[TOD_BITS-1:0] == alarm_q[TOD_BITS-1:0]);
   assign day_hit = tod_hit & (next_i[WORD_W-1:TOD_BITS] == alarm_q[WORD_W-1:TOD_BITS]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q   <= '0;
         tod_evt_o <= 1'b0;
         day_evt_o <= 1'b0;
      end else begin
         if (load_i) alarm_q <= load_val_i;
         tod_evt_o <= step_i & ~time_load_i & tod_hit;
         day_evt_o <= step_i & ~time_load_i & day_hit;
      end
   end

   AST_DAY_NEEDS_TOD: assert property (@(posedge clk) disable iff (!rst_n)
      day_evt_o |-> tod_evt_o); // R9
   AST_ALARM_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tod_evt_o |-> $past(step_i)); // R8
endmodule

// File: rtl/pkd_countdown.sv
module pkd_countdown #(
   parameter int unsigned SW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_i,
   input  logic            load_i,
   input  logic [SW_W-1:0] load_val_i,
   output logic [SW_W-1:0] cnt_o,
   output logic            zero_evt_o
);
   if (SW_W < 2) begin : g_bad_w
      $error("pkd_countdown: SW_W must be at least 2");
   end

   logic [SW_W-1:0] sw_q;
   logic            nonzero, last;

   assign nonzero = |sw_q;
   assign last    = (sw_q == SW_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q       <= '0;
         zero_evt_o <= 1'b0;
      end else begin
         if (load_i) begin
            sw_q <= load_val_i;
         end else if (step_i && nonzero) begin
            sw_q <= sw_q - 1'b1;
         end
         zero_evt_o <= step_i & ~load_i & last;
      end
   end

   assign cnt_o = sw_q;

   AST_SW_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt_o |-> (sw_q == '0)); // R10
   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && step_i && !nonzero) |=> (sw_q == '0 && !zero_evt_o)); // R10
   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sw_q == $past(load_val_i))); // R11
endmodule

// File: rtl/pkd_timekeeper.sv
module pkd_timekeeper
   import pkd_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV = 32768,
   parameter int unsigned SW_W         = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              div_en,
   input  logic              time_load,
   input  logic [WORD_W-1:0] time_load_val,
   input  logic              alarm_load,
   input  logic [WORD_W-1:0] alarm_load_val,
   input  logic              swatch_load,
   input  logic [SW_W-1:0]   swatch_load_val,
   output logic [WORD_W-1:0] time_word,
   output logic [SW_W-1:0]   swatch_word,
   output logic [EVT_W-1:0]  event_pulse
);
   logic              step;
   logic [WORD_W-1:0] next_word;
   logic [3:0]        roll_evt;
   logic              tod_evt, day_evt, sw_evt;

   pkd_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick), .div_en_i(div_en),
      .load_i(time_load), .step_o(step)
   );

   pkd_tod_counter u_tod (
      .clk(clk), .rst_n(rst_n), .step_i(step), .load_i(time_load),
      .load_val_i(time_load_val), .cnt_o(time_word), .next_o(next_word),
      .roll_evt_o(roll_evt)
   );

   pkd_alarm_cmp u_alarm (
      .clk(clk), .rst_n(rst_n), .step_i(step), .time_load_i(time_load),
      .next_i(next_word), .load_i(alarm_load), .load_val_i(alarm_load_val),
      .tod_evt_o(tod_evt), .day_evt_o(day_evt)
   );

   pkd_countdown #(.SW_W(SW_W)) u_swatch (
      .clk(clk), .rst_n(rst_n), .step_i(step), .load_i(swatch_load),
      .load_val_i(swatch_load_val), .cnt_o(swatch_word), .zero_evt_o(sw_evt)
   );

   always_comb begin
      event_pulse           = '0;
      event_pulse[EVT_SW]   = sw_evt;
      event_pulse[EVT_TALM] = tod_evt;
      event_pulse[EVT_SEC]  = roll_evt[0];
      event_pulse[EVT_MIN]  = roll_evt[1];
      event_pulse[EVT_HR]   = roll_evt[2];
      event_pulse[EVT_DAY]  = roll_evt[3];
      event_pulse[EVT_DALM] = day_evt;
   end

   AST_EVENTS_NEED_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (|event_pulse[EVT_DALM:EVT_TALM]) |-> event_pulse[EVT_SEC]); // R2
endmodule

// File: tb/pkd_timekeeper_tb.sv
module pkd_timekeeper_tb;
   localparam int unsigned DIV  = 4;
   localparam int unsigned SW_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            osc_tick = 1'b0, div_en = 1'b0;
   logic            time_load = 1'b0, alarm_load = 1'b0, swatch_load = 1'b0;
   logic [31:0]     time_load_val = '0, alarm_load_val = '0;
   logic [SW_W-1:0] swatch_load_val = '0;
   logic [31:0]     time_word;
   logic [SW_W-1:0] swatch_word;
   logic [6:0]      event_pulse;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pkd_timekeeper #(.PRESCALE_DIV(DIV), .SW_W(SW_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .div_en(div_en),
      .time_load(time_load), .time_load_val(time_load_val),
      .alarm_load(alarm_load), .alarm_load_val(alarm_load_val),
      .swatch_load(swatch_load), .swatch_load_val(swatch_load_val),
      .time_word(time_word), .swatch_word(swatch_word), .event_pulse(event_pulse)
   );

   function automatic logic [31:0] pk(int d, int h, int m, int s);
      return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
   endtask

   task automatic ld_time(logic [31:0] v);
      @(negedge clk); time_load = 1'b1; time_load_val = v;
      @(negedge clk); time_load = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 time", time_word, 0);
      check("R1 swatch", 32'(swatch_word), 0);
      check("R1 events", 32'(event_pulse), 0);
   endtask

   task automatic t_second();
      ld_time(pk(0, 1, 2, 3));
      tick();
      check("R2 count", time_word, pk(0, 1, 2, 4));
      check("R2 event", 32'(event_pulse), 32'h04);
      @(negedge clk);
      check("R2 pulse width", 32'(event_pulse), 0);
   endtask

   task automatic t_tod_alarm();
      @(negedge clk); alarm_load = 1'b1; alarm_load_val = pk(5, 10, 20, 30);
      @(negedge clk); alarm_load = 1'b0;
      ld_time(pk(9, 10, 20, 29));
      tick();
      check("R8 R12 tod alarm", 32'(event_pulse), 32'h06);
   endtask

   task automatic t_day_alarm();
      ld_time(pk(5, 10, 20, 29));
      tick();
      check("R9 day alarm", 32'(event_pulse), 32'h46);
      tick();
      check("R9 no repeat", 32'(event_pulse), 32'h04);
   endtask

   task automatic t_wraps();
      ld_time(pk(0, 0, 3, 59));
      tick();
      check("R3 count", time_word, pk(0, 0, 4, 0));
      check("R3 event", 32'(event_pulse), 32'h0C);
      ld_time(pk(0, 22, 59, 59));
      tick();
      check("R4 count", time_word, pk(0, 23, 0, 0));
      check("R4 event", 32'(event_pulse), 32'h1C);
      ld_time(pk(7, 23, 59, 59));
      tick();
      check("R5 count", time_word, pk(8, 0, 0, 0));
      check("R5 event", 32'(event_pulse), 32'h3C);
      ld_time(pk(32767, 23, 59, 59));
      tick();
      check("R5 day max wrap", time_word, 0);
      check("R5 day max event", 32'(event_pulse), 32'h3C);
   endtask

   task automatic t_prescale();
      div_en = 1'b1;
      ld_time(pk(1, 2, 3, 4));
      for (int i = 1; i < int'(DIV); i++) begin
         tick();
         check("R6 no step before period", time_word, pk(1, 2, 3, 4));
      end
      tick();
      check("R6 step after period", time_word, pk(1, 2, 3, 5));
      check("R6 event", 32'(event_pulse), 32'h04);
      tick(); tick();
      ld_time(pk(1, 2, 3, 9));
      for (int i = 1; i < int'(DIV); i++) tick();
      check("R7 phase cleared", time_word, pk(1, 2, 3, 9));
      tick();
      check("R7 full period", time_word, pk(1, 2, 3, 10));
      div_en = 1'b0;
   endtask

   task automatic t_collision();
      @(negedge clk); swatch_load = 1'b1; swatch_load_val = 16'd5;
      @(negedge clk); swatch_load = 1'b0;
      @(negedge clk); time_load = 1'b1; time_load_val = pk(3, 4, 5, 6); osc_tick = 1'b1;
      @(negedge clk); time_load = 1'b0; osc_tick = 1'b0;
      check("R7 load wins", time_word, pk(3, 4, 5, 6));
      check("R7 no event", 32'(event_pulse), 0);
      check("R7 swatch untouched", 32'(swatch_word), 5);
      @(negedge clk); swatch_load = 1'b1; swatch_load_val = 16'd9; osc_tick = 1'b1;
      @(negedge clk); swatch_load = 1'b0; osc_tick = 1'b0;
      check("R11 load wins", 32'(swatch_word), 9);
      check("R11 time still steps", time_word, pk(3, 4, 5, 7));
   endtask

   task automatic t_stopwatch();
      @(negedge clk); swatch_load = 1'b1; swatch_load_val = 16'd2;
      @(negedge clk); swatch_load = 1'b0;
      tick();
      check("R10 decrement", 32'(swatch_word), 1);
      check("R10 no flag yet", 32'(event_pulse[0]), 0);
      tick();
      check("R10 zero", 32'(swatch_word), 0);
      check("R10 zero flag", 32'(event_pulse[0]), 1);
      tick();
      check("R10 hold", 32'(swatch_word), 0);
      check("R10 flag once", 32'(event_pulse[0]), 0);
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_second();
      t_tod_alarm();
      t_day_alarm();
      t_wraps();
      t_prescale();
      t_collision();
      t_stopwatch();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule